// File: doc/BRIEF.md
# DMA Interrupt Flag and Request Register

This block is the interrupt bookkeeping register of a seven-channel DMA controller. Software sees it as a single 32-bit word: it writes per-channel enables, a master gate and a force bit, and reads back those settings together with the pending completion flags and the live state of the request line. The channel engines around it drive two kinds of event into it: a one-cycle completion pulse per channel, and a one-cycle bus-error pulse.

A completion sets that channel's pending flag only when its enable is on at that moment. Software acknowledges a flag by writing a one into its position. The request line to the CPU interrupt controller is high when the force bit is set, or when the master gate is on and at least one enabled channel has a pending flag. A bus error sets the force bit, so the line goes high no matter what the gate and enables hold.

The block holds flags and produces the request line. It does not arbitrate channels or move data. Only full-word accesses are modelled. The request line is registered and settles one clock after the event that changes it.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset, every stored bit is zero: rdData reads 0x00000000 and irqOut is low.
- R2: A write stores only bits 23:16, bit 15 and bits 5:0 (mask 0x00FF803F) as settings. Bits 14:6 always read zero.
- R3: A completion pulse on doneIn[n] sets the pending flag read at bit 24+n only if the enable at bit 16+n holds a one before that clock edge. Otherwise nothing changes.
- R4: Writing a one at bit 24+n clears pending flag n. Writing a zero there leaves the flag as it was.
- R5: irqOut is bit 15 OR (bit 23 AND any bit of (pending flags AND enables)). Clearing the master gate or a channel's enable masks its pending flag without clearing it.
- R6: A busErrIn pulse sets bit 15, which drives irqOut high. Writing a zero into bit 15 clears it again.
- R7: Bit 31 of rdData always equals irqOut.
- R8: irqOut is registered. It changes on the clock edge that takes the write, completion or error, and it stays unchanged when none of these occurs.
- R9: When a completion and an acknowledge write hit the same flag in one cycle, the flag ends up set.
- R10: When a bus error and a write of zero into bit 15 occur in one cycle, bit 15 ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Full-word write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read view: settings, pending flags at 30:24, request at 31 |
| doneIn | input | 7 | One-cycle completion pulse per channel |
| busErrIn | input | 1 | One-cycle bus-error pulse |
| irqOut | output | 1 | Interrupt request to the CPU |

## Verification
The hardest cases to reach are the same-cycle collisions. In one, a completion and its acknowledge land on the same edge. In the other, a bus error lands on the same edge as a write that clears the force bit. The directed tasks drive both events on one negative edge so that they share a single rising edge, then read the register back. The one-clock latency of the request line is checked by sampling irqOut just before the edge that takes a write, and again just after it.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int CH_COUNT = 7;

  // Per-cycle strobes handed from the control decoder to the datapath
  typedef struct packed {
    logic                wr;
    logic                err;
    logic [CH_COUNT-1:0] setMask;
    logic [CH_COUNT-1:0] clrMask;
  } irqStrobeT;
endpackage

// File: rtl/dma_irq_ctl.sv
module dma_irq_ctl
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH  = CH_COUNT,
  parameter int DATA_W  = 32,
  parameter int STAT_LSB = 24
) (
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_CH-1:0] doneIn,
  input  logic              busErrIn,
  input  logic [NUM_CH-1:0] enaBits,
  output irqStrobeT         stb
);
  logic unusedWr;
  assign unusedWr = ^{wrData[STAT_LSB-1:0], wrData[DATA_W-1:STAT_LSB+NUM_CH]};

  always_comb begin
    stb.wr      = wrEn;
    stb.err     = busErrIn;
    // a completion counts only for a channel enabled before this edge
    stb.setMask = doneIn & enaBits;
    stb.clrMask = wrEn ? wrData[STAT_LSB +: NUM_CH] : '0;
  end
endmodule

// File: rtl/dma_irq_dp.sv
module dma_irq_dp
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH    = CH_COUNT,
  parameter int DATA_W    = 32,
  parameter int LOW_W     = 6,
  parameter int FORCE_BIT = 15,
  parameter int ENA_LSB   = 16,
  parameter int STAT_LSB  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  irqStrobeT         stb,
  output logic [NUM_CH-1:0] enaBits,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  localparam int MASTER_BIT = ENA_LSB + NUM_CH;

  logic [LOW_W-1:0]  lowBits, lowNext;
  logic              forceBit, forceNext;
  logic              masterEn, masterNext;
  logic [NUM_CH-1:0] enaNext;
  logic [NUM_CH-1:0] pendBits, pendNext;
  logic              irqNext;

  // settings
  always_comb begin
    lowNext    = stb.wr ? wrData[LOW_W-1:0]       : lowBits;
    enaNext    = stb.wr ? wrData[ENA_LSB +: NUM_CH] : enaBits;
    masterNext = stb.wr ? wrData[MASTER_BIT]      : masterEn;
    forceNext  = stb.wr ? wrData[FORCE_BIT]       : forceBit;
    if (stb.err) forceNext = 1'b1;   // error beats a same-cycle clear
  end

  // pending flags, one per channel: a new completion beats an acknowledge
  for (genvar c = 0; c < NUM_CH; c++) begin : gPend
    always_comb pendNext[c] = stb.setMask[c] | (pendBits[c] & ~stb.clrMask[c]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pendBits[c] <= 1'b0;
      else       pendBits[c] <= pendNext[c];
    end
  end

  assign irqNext = forceNext | (masterNext & |(pendNext & enaNext));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowBits  <= '0;
      enaBits  <= '0;
      masterEn <= 1'b0;
      forceBit <= 1'b0;
      irqOut   <= 1'b0;
    end else begin
      lowBits  <= lowNext;
      enaBits  <= enaNext;
      masterEn <= masterNext;
      forceBit <= forceNext;
      irqOut   <= irqNext;
    end
  end

  always_comb begin
    rdData                      = '0;
    rdData[LOW_W-1:0]           = lowBits;
    rdData[FORCE_BIT]           = forceBit;
    rdData[ENA_LSB +: NUM_CH]   = enaBits;
    rdData[MASTER_BIT]          = masterEn;
    rdData[STAT_LSB +: NUM_CH]  = pendBits;
    rdData[DATA_W-1]            = irqOut;
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = CH_COUNT,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [NUM_CH-1:0] doneIn,
  input  logic              busErrIn,
  output logic              irqOut
);
  irqStrobeT         stb;
  logic [NUM_CH-1:0] enaBits;

  dma_irq_ctl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) ctl_i (
    .wrEn(wrEn), .wrData(wrData), .doneIn(doneIn), .busErrIn(busErrIn),
    .enaBits(enaBits), .stb(stb)
  );

  dma_irq_dp #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .wrData(wrData), .stb(stb),
    .enaBits(enaBits), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: rtl/dma_irq_chk.sv
module dma_irq_chk #(
  parameter int NUM_CH = 7,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [NUM_CH-1:0] doneIn,
  input logic              busErrIn,
  input logic [DATA_W-1:0] rdData,
  input logic              irqOut
);
  localparam int ENA_LSB  = 16;
  localparam int STAT_LSB = 24;

  p_read_irq_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1] == irqOut);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[14:6] == '0);

  p_irq_combine_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (rdData[15] | (rdData[ENA_LSB+NUM_CH] &
               |(rdData[STAT_LSB +: NUM_CH] & rdData[ENA_LSB +: NUM_CH]))));

  p_err_forces_r6: assert property (@(posedge clk) disable iff (!rstN)
    busErrIn |=> (rdData[15] && irqOut));

  // covers the set-wins collision of R9 as well
  p_done_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|(doneIn & rdData[ENA_LSB +: NUM_CH])) |=>
      ((rdData[STAT_LSB +: NUM_CH] & $past(doneIn & rdData[ENA_LSB +: NUM_CH]))
        == $past(doneIn & rdData[ENA_LSB +: NUM_CH])));

  p_quiet_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && doneIn == '0 && !busErrIn) |=> $stable(rdData));
endmodule

bind dma_irq_ctrl dma_irq_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .doneIn(doneIn),
  .busErrIn(busErrIn), .rdData(rdData), .irqOut(irqOut)
);

// File: tb/dma_irq_ctrl_tb_top.sv
module dma_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [6:0]  doneIn = '0;
  logic        busErrIn = 1'b0;
  logic        irqOut;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  dma_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .doneIn(doneIn), .busErrIn(busErrIn), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all drives at negedge; results sampled at the following negedge
  task automatic cycle(input logic w, input logic [31:0] d,
                       input logic [6:0] dn, input logic e);
    @(negedge clk);
    wrEn = w; wrData = d; doneIn = dn; busErrIn = e;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; doneIn = '0; busErrIn = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rdData", rdData, 32'h0);
    chk("R1 irq", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_mask;
    cycle(1'b1, 32'hFFFF_FFFF, '0, 1'b0);
    chk("R2 mask", rdData, 32'h80FF_803F);
    chk("R7 bit31", {31'b0, rdData[31]}, {31'b0, irqOut});
    cycle(1'b1, 32'h0, '0, 1'b0);
    chk("R2 clear", rdData, 32'h0);
  endtask

  task automatic t_gated_set;
    cycle(1'b1, 32'h0015_0000, '0, 1'b0);
    cycle(1'b0, 32'h0, 7'h7F, 1'b0);
    chk("R3 gated set", rdData, 32'h1515_0000);
    chk("R5 master off", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_master_latency;
    @(negedge clk);
    wrEn = 1'b1; wrData = 32'h0095_0000;
    #1 chk("R8 before edge", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    chk("R8 after edge", {31'b0, irqOut}, 32'h1);
    chk("R5 R7 master on", rdData, 32'h9595_0000);
    repeat (3) @(negedge clk);
    chk("R8 held", rdData, 32'h9595_0000);
  endtask

  task automatic t_ack;
    cycle(1'b1, 32'h0295_0000, '0, 1'b0);
    chk("R4 clear unset", rdData, 32'h9595_0000);
    cycle(1'b1, 32'h0495_0000, '0, 1'b0);
    chk("R4 clear one", rdData, 32'h9195_0000);
    cycle(1'b1, 32'h1195_0000, '0, 1'b0);
    chk("R4 clear rest", rdData, 32'h0095_0000);
  endtask

  task automatic t_mask_keep;
    cycle(1'b0, 32'h0, 7'h01, 1'b0);
    chk("R5 pend irq", rdData, 32'h8195_0000);
    cycle(1'b1, 32'h0080_0000, '0, 1'b0);
    chk("R5 ena off keeps flag", rdData, 32'h0180_0000);
    cycle(1'b0, 32'h0, 7'h01, 1'b0);
    chk("R3 disabled no set", rdData, 32'h0180_0000);
    cycle(1'b1, 32'h0100_0000, '0, 1'b0);
    chk("R4 clear", rdData, 32'h0);
  endtask

  task automatic t_err;
    cycle(1'b0, 32'h0, '0, 1'b1);
    chk("R6 error", rdData, 32'h8000_8000);
    cycle(1'b1, 32'h0, '0, 1'b0);
    chk("R6 clear", rdData, 32'h0);
  endtask

  task automatic t_collide;
    cycle(1'b1, 32'h0081_0000, '0, 1'b0);
    cycle(1'b0, 32'h0, 7'h01, 1'b0);
    chk("R9 setup", rdData, 32'h8181_0000);
    cycle(1'b1, 32'h0181_0000, 7'h01, 1'b0);
    chk("R9 set wins", rdData, 32'h8181_0000);
    cycle(1'b1, 32'h0181_0000, '0, 1'b0);
    chk("R9 later ack", rdData, 32'h0081_0000);
    cycle(1'b1, 32'h0, '0, 1'b1);
    chk("R10 error wins", rdData, 32'h8000_8000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_gated_set();
    t_master_latency();
    t_ack();
    t_mask_keep();
    t_err();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule